// File: doc/BRIEF.md
# Window Watchdog Supervisor

This block supervises an external microcontroller. It runs from a free-running oscillator clock. It watches one trigger line that the software must toggle. The toggle must arrive inside a timed window that opens only after a closed period. If the toggle comes too early, or does not come at all, the block pulls the microcontroller reset low for a fixed time and then starts supervising again. Power is reported to the block as a clean, synchronous power-good level. While power is bad, the reset is held low.

A prescaler divides the oscillator into the watchdog cycle, and every duration is counted in these cycles. The trigger line is synchronised and sampled once per cycle. A trigger is the sample sequence HIGH, HIGH, LOW, LOW, and it is recognised on the tick that takes its fourth sample. The window state machine has these states:

- `WS_OFF`: power bad.
- `WS_DELAY`: power-up reset.
- `WS_CLOSED`: early triggers are forbidden.
- `WS_OPEN`: a trigger is expected.
- `WS_PRETRIG`: an early trigger was seen, and the machine waits for the reset instant.
- `WS_FAULT`: failure reset low.

Its transitions are:

- power-good (OFF→DELAY)
- delay-done (DELAY→CLOSED)
- closed-elapsed (CLOSED→OPEN)
- early-trigger (CLOSED→PRETRIG)
- good-trigger (OPEN→CLOSED)
- open-timeout (OPEN→FAULT)
- lead-elapsed (PRETRIG→FAULT)
- fault-done (FAULT→CLOSED)
- power-loss (any→OFF)

Top module: `wdg_window_supervisor`

## Requirements
- R1: While `pwr_good` is 0, `mcu_rst_n` is 0 from the first clock edge that samples it low, and all timing restarts.
- R2: After `pwr_good` rises, `mcu_rst_n` stays 0 for 64 watchdog cycles and then goes to 1.
- R3: One watchdog cycle is `CYCLE_DIV` oscillator clocks, and every window and reset length is a whole number of cycles.
- R4: A closed window of 32 cycles starts when `mcu_rst_n` goes to 1, and again after each accepted trigger. A trigger whose fourth sample falls in the closed window is a pretrigger failure.
- R5: An open window of up to 32 cycles follows the closed window. A trigger completed in it starts a new closed window at once, and `mcu_rst_n` stays 1.
- R6: If no trigger completes during the open window, a failure reset follows.
- R7: A failure reset drives `mcu_rst_n` to 0 exactly 64 cycles after the start of the latest closed window, even if a trigger arrives after a pretrigger. It then holds 0 for 64 cycles, and the rising edge begins a closed window.
- R8: `wd_trig` is sampled once per cycle, and a trigger is only the sample run 1,1,0,0 (oldest first). Any other run, such as a single high sample, is not a trigger.
- R9: A trigger whose first three samples lie in the closed window and whose fourth sample is the first sample of the open window is accepted as good.
- R10: Trigger activity while `mcu_rst_n` is 0 has no effect on the length of the reset.
- R11: The sample history is cleared whenever a closed window starts, so a trigger needs two fresh high samples after each restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| pwr_good | input | 1 | Synchronous supply-valid level; low clears the block |
| wd_trig | input | 1 | Asynchronous trigger line from the microcontroller |
| mcu_rst_n | output | 1 | Active-low microcontroller reset |

## Verification
The hardest situation to reach is the R11 case, where a stale sample history would turn a falling level into a pretrigger just after a restart. From the ports this only shows up when the trigger line has been high across the end of a reset, so that the history is full of high samples at the moment the closed window begins. The stimulus raises the trigger line while the failure reset is low. It drops the line half a cycle after the reset releases, and then gives a proper trigger in the open window, so a stale history shows up as an unexpected reset. The edges of the R9 boundary and the late trigger after a pretrigger are placed by counting ticks from the observed rising edge of the reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [2:0] {
        WS_OFF,
        WS_DELAY,
        WS_CLOSED,
        WS_OPEN,
        WS_PRETRIG,
        WS_FAULT
    } wdg_state_e;
endpackage

// File: rtl/wdg_cycle_prescaler.sv
module wdg_cycle_prescaler #(
    parameter int CYCLE_DIV = 100
) (
    input  logic clk,
    input  logic run,
    output logic tick
);
    generate
        if (CYCLE_DIV <= 1) begin : g_passthru
            assign tick = run;
        end else begin : g_div
            localparam int PRE_W = $clog2(CYCLE_DIV);
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (!run) begin
                    pre_q <= '0;
                end else if (pre_q == PRE_W'(CYCLE_DIV - 1)) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick = run && (pre_q == PRE_W'(CYCLE_DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/wdg_trig_sampler.sv
module wdg_trig_sampler (
    input  logic clk,
    input  logic run,
    input  logic tick,
    input  logic clr,
    input  logic trig_raw,
    output logic trig_valid
);
    logic       sync1_q;
    logic       sync2_q;
    logic [2:0] hist_q;   // [2] oldest of the last three samples

    always_ff @(posedge clk) begin
        if (!run) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= trig_raw;
            sync2_q <= sync1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!run || clr) begin
            hist_q <= 3'b000;
        end else if (tick) begin
            hist_q <= {hist_q[1:0], sync2_q};
        end
    end

    // fourth sample (LOW) completes the high-high-low-low run
    assign trig_valid = tick && (hist_q == 3'b110) && !sync2_q;
endmodule

// File: rtl/wdg_window_fsm.sv
module wdg_window_fsm
    import wdg_pkg::*;
#(
    parameter int DELAY_CYC  = 64,
    parameter int CLOSED_CYC = 32,
    parameter int OPEN_CYC   = 32,
    parameter int LEAD_CYC   = 64,
    parameter int LOW_CYC    = 64
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic tick,
    input  logic trig_valid,
    output logic hist_clr,
    output logic rst_n_o
);
    localparam int WIN_CYC = CLOSED_CYC + OPEN_CYC;
    localparam int MAX_A   = (DELAY_CYC > WIN_CYC) ? DELAY_CYC : WIN_CYC;
    localparam int MAX_B   = (LEAD_CYC > LOW_CYC) ? LEAD_CYC : LOW_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    wdg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WS_OFF: begin
                state_d = WS_DELAY;
                cnt_d   = '0;
            end
            WS_DELAY: begin
                if (tick) begin
                    if (cnt_q == CNT_W'(DELAY_CYC - 1)) begin
                        state_d = WS_CLOSED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            WS_CLOSED: begin
                if (tick) begin
                    cnt_d = cnt_q + 1'b1;
                    if (trig_valid) begin
                        state_d = WS_PRETRIG;
                    end else if (cnt_q == CNT_W'(CLOSED_CYC - 1)) begin
                        state_d = WS_OPEN;
                    end
                end
            end
            WS_OPEN: begin
                if (tick) begin
                    if (trig_valid) begin
                        state_d = WS_CLOSED;
                        cnt_d   = '0;
                    end else if (cnt_q == CNT_W'(WIN_CYC - 1)) begin
                        state_d = WS_FAULT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            WS_PRETRIG: begin
                if (tick) begin
                    if (cnt_q >= CNT_W'(LEAD_CYC - 1)) begin
                        state_d = WS_FAULT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            WS_FAULT: begin
                if (tick) begin
                    if (cnt_q == CNT_W'(LOW_CYC - 1)) begin
                        state_d = WS_CLOSED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = WS_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            state_q <= WS_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        hist_clr = (state_d == WS_CLOSED) && (state_q != WS_CLOSED);
        unique case (state_q)
            WS_CLOSED, WS_OPEN, WS_PRETRIG: rst_n_o = 1'b1;
            default:                        rst_n_o = 1'b0;
        endcase
    end

    // R5: leaving the open window early needs an accepted trigger
    assert_open_needs_trigger_R5: assert property (@(posedge clk) disable iff (!pwr_good)
        (state_q == WS_OPEN && !trig_valid) |=> (state_q != WS_CLOSED));

    // R4: a trigger completed in the closed window is a pretrigger
    assert_pretrigger_detected_R4: assert property (@(posedge clk) disable iff (!pwr_good)
        (state_q == WS_CLOSED && trig_valid) |=> (state_q == WS_PRETRIG));

    // R7 and R10: the failure reset holds until its last cycle
    assert_fault_holds_R7: assert property (@(posedge clk) disable iff (!pwr_good)
        (state_q == WS_FAULT && !(tick && cnt_q == CNT_W'(LOW_CYC - 1)))
        |=> (state_q == WS_FAULT));

    // R3: the state changes only on a cycle tick
    assert_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!pwr_good)
        (!tick && state_q != WS_OFF) |=> $stable(state_q));
endmodule

// File: rtl/wdg_window_supervisor.sv
module wdg_window_supervisor #(
    parameter int CYCLE_DIV  = 100,
    parameter int DELAY_CYC  = 64,
    parameter int CLOSED_CYC = 32,
    parameter int OPEN_CYC   = 32,
    parameter int LEAD_CYC   = 64,
    parameter int LOW_CYC    = 64
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic wd_trig,
    output logic mcu_rst_n
);
    logic tick;
    logic trig_valid;
    logic hist_clr;

    wdg_cycle_prescaler #(
        .CYCLE_DIV(CYCLE_DIV)
    ) u_prescaler (
        .clk (clk),
        .run (pwr_good),
        .tick(tick)
    );

    wdg_trig_sampler u_sampler (
        .clk       (clk),
        .run       (pwr_good),
        .tick      (tick),
        .clr       (hist_clr),
        .trig_raw  (wd_trig),
        .trig_valid(trig_valid)
    );

    wdg_window_fsm #(
        .DELAY_CYC (DELAY_CYC),
        .CLOSED_CYC(CLOSED_CYC),
        .OPEN_CYC  (OPEN_CYC),
        .LEAD_CYC  (LEAD_CYC),
        .LOW_CYC   (LOW_CYC)
    ) u_fsm (
        .clk       (clk),
        .pwr_good  (pwr_good),
        .tick      (tick),
        .trig_valid(trig_valid),
        .hist_clr  (hist_clr),
        .rst_n_o   (mcu_rst_n)
    );
endmodule

// File: tb/wdg_window_supervisor_tb.sv
module wdg_window_supervisor_tb;
    localparam int DIV = 10;

    logic clk = 1'b0;
    logic pwr_good = 1'b0;
    logic wd_trig = 1'b0;
    logic mcu_rst_n;

    int clk_n = 0;
    int t0 = 0;
    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) clk_n <= clk_n + 1;

    wdg_window_supervisor #(.CYCLE_DIV(DIV)) u_dut (
        .clk      (clk),
        .pwr_good (pwr_good),
        .wd_trig  (wd_trig),
        .mcu_rst_n(mcu_rst_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at clock %0d", req, act, exp, clk_n);
        end
    endtask

    task automatic wait_until(input int t);
        while (clk_n < t) @(negedge clk);
    endtask

    // mid-point between tick j and tick j+1 of the current window origin
    task automatic at(input int j);
        wait_until(t0 + DIV * j + DIV / 2);
    endtask

    task automatic expect_rst(input int off, input logic val, input string req);
        wait_until(t0 + off);
        check(mcu_rst_n === val, req, int'(mcu_rst_n), int'(val));
    endtask

    // trigger whose fourth sample is taken on tick m
    task automatic fire(input int m);
        at(m - 4);
        wd_trig = 1'b1;
        at(m - 2);
        wd_trig = 1'b0;
    endtask

    task automatic t_reset_state;
        repeat (5) @(negedge clk);
        check(mcu_rst_n === 1'b0, "R1 reset state", int'(mcu_rst_n), 0);
    endtask

    task automatic t_powerup;
        int p;
        @(negedge clk);
        p = clk_n;
        pwr_good = 1'b1;
        t0 = p;
        expect_rst(64 * DIV - DIV / 2, 1'b0, "R2 delay low");
        expect_rst(64 * DIV + DIV / 2, 1'b1, "R3 delay release");
        t0 = p + 64 * DIV;
    endtask

    task automatic t_open_trigger;
        fire(40);
        expect_rst(64 * DIV + DIV / 2, 1'b1, "R5 trigger at 40 kept reset high");
        t0 = t0 + 40 * DIV;
        fire(50);
        expect_rst(64 * DIV + DIV / 2, 1'b1, "R8 trigger at 50 kept reset high");
        t0 = t0 + 50 * DIV;
    endtask

    task automatic t_boundary;
        fire(33);
        expect_rst(64 * DIV + DIV / 2, 1'b1, "R9 fourth sample in open accepted");
        t0 = t0 + 33 * DIV;
    endtask

    task automatic t_timeout;
        expect_rst(64 * DIV - DIV / 2, 1'b1, "R6 high before timeout");
        expect_rst(64 * DIV + DIV / 2, 1'b0, "R6 timeout reset");
        expect_rst(128 * DIV - DIV / 2, 1'b0, "R7 reset still low");
        expect_rst(128 * DIV + DIV / 2, 1'b1, "R7 reset released");
        t0 = t0 + 128 * DIV;
    endtask

    task automatic t_pretrigger;
        fire(32);
        fire(40);
        expect_rst(64 * DIV - DIV / 2, 1'b1, "R7 high until lead ends");
        expect_rst(64 * DIV + DIV / 2, 1'b0, "R4 pretrigger reset despite later trigger");
        fire(80);
        expect_rst(128 * DIV - DIV / 2, 1'b0, "R10 trigger during reset ignored");
        expect_rst(128 * DIV + DIV / 2, 1'b1, "R10 reset length unchanged");
        t0 = t0 + 128 * DIV;
    endtask

    task automatic t_glitch_then_stale_high;
        at(35);
        wd_trig = 1'b1;
        at(36);
        wd_trig = 1'b0;
        at(50);
        wd_trig = 1'b1;
        at(51);
        wd_trig = 1'b0;
        expect_rst(64 * DIV + DIV / 2, 1'b0, "R8 single high samples are no trigger");
        at(100);
        wd_trig = 1'b1;
        expect_rst(128 * DIV + DIV / 2, 1'b1, "R8 reset released");
        t0 = t0 + 128 * DIV;
        at(0);
        wd_trig = 1'b0;
        fire(40);
        expect_rst(64 * DIV + DIV / 2, 1'b1, "R11 history cleared at restart");
        t0 = t0 + 40 * DIV;
    endtask

    task automatic t_power_loss;
        int p;
        at(20);
        pwr_good = 1'b0;
        @(negedge clk);
        check(mcu_rst_n === 1'b0, "R1 power loss drives reset", int'(mcu_rst_n), 0);
        repeat (20) @(negedge clk);
        check(mcu_rst_n === 1'b0, "R1 reset held while power bad", int'(mcu_rst_n), 0);
        p = clk_n;
        pwr_good = 1'b1;
        t0 = p;
        expect_rst(64 * DIV - DIV / 2, 1'b0, "R2 delay restarts");
        expect_rst(64 * DIV + DIV / 2, 1'b1, "R2 release after repower");
    endtask

    initial begin
        t_reset_state();
        t_powerup();
        t_open_trigger();
        t_boundary();
        t_timeout();
        t_pretrigger();
        t_glitch_then_stale_high();
        t_power_loss();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", clk_n, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule